// File: doc/BRIEF.md
# Byte-Addressed Serial Control Register Bank

This block holds a wide bank of static control bits (by default 20 bytes, 160 bits) that steer analog and RF settings such as gain steps, phase trims and capacitor banks. A controller loads it over a single serial data line. Each write frame carries one byte and selects one output byte through a set of one-line-per-byte select inputs. Only the selected byte changes, so a single setting is updated in ten clocks. A plain shift chain would need one clock for every bit of the whole bank.

A frame is ten consecutive rising edges with the strobe held high. On edges 1 to 8 the serial bits enter an input shift stage, most significant bit first. On edge 9 the assembled byte is copied into a holding stage. On edge 10 the select lines are decoded and the held byte is written into the one addressed output byte. That byte then keeps its value until it is written again or reset. A sequencer with four named states paces the frame:
- `ST_IDLE` goes to `ST_SHIFT` when the strobe is high, taking the first bit.
- `ST_SHIFT` returns to `ST_IDLE` if the strobe drops. It moves to `ST_LOAD` on the edge that takes the eighth bit.
- `ST_LOAD` goes to `ST_COMMIT` if the strobe is high, and otherwise back to `ST_IDLE`.
- `ST_COMMIT` always returns to `ST_IDLE`.

If more than one select line is high at the commit edge, the write is refused and an error flag pulses for one cycle.

Top module: `ctl_s2p_bank`

## Requirements
- R1: A synchronous, active-high reset clears all output bits to 0, clears the error flag, and returns the sequencer to idle. A frame in progress is abandoned.
- R2: Serial bits are taken most significant bit first: the first bit of a frame lands in bit 7 of the target byte. Output byte k occupies `ctl_out[8k+7:8k]`.
- R3: With the strobe high on ten consecutive edges starting from idle, the target byte keeps its old value after edge 9 and shows the new value after edge 10.
- R4: A write changes only the byte whose select line (`byte_sel[k]` for byte k) is high. All other bytes keep their values.
- R5: While the strobe is low, no output bit changes, whatever the serial data and select lines do.
- R6: If no select line is high at the commit edge, no output byte changes and the error flag stays low.
- R7: If two or more select lines are high at the commit edge, no output byte changes. The error flag is high for exactly the one cycle after that edge.
- R8: If the strobe is low on any of the ten edges of a frame, the frame is discarded without a write. The next frame starts from the first bit.
- R9: A new frame may start on the edge right after a commit edge. With the strobe held high, a second write lands 10 edges after the first.
- R10: The select lines are sampled only at the commit edge (edge 10). Their values during edges 1 to 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial data bit, first bit is the byte MSB |
| strobe | input | 1 | Frame enable, held high for the ten edges of a write |
| byte_sel | input | 20 | One line per output byte; exactly one high at the commit edge |
| ctl_out | output | 160 | Parallel control bits, byte k at [8k+7:8k] |
| sel_err | output | 1 | One-cycle pulse when a commit sees several select lines high |

## Verification
A wrong bit count or a slipped sequencer state shows at the ports at the end of the frame. It appears either as a byte that changes one edge early or late, or as a rotated value in the target byte. For that reason the bench samples the target byte just before and just after edge 10. A stuck holding stage or bad decode appears right after the commit as a neighbour byte that changed, or a wrong byte that received the data. An abandoned frame that was not flushed corrupts the byte written by the next full frame, so abort cases are always followed by a clean write.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LOAD   = 2'd2,
        ST_COMMIT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/s2p_seq_fsm.sv
module s2p_seq_fsm
    import s2p_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic shift_en,
    output logic hold_en,
    output logic commit_en
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (strobe) begin
                    cnt_d   = CNT_W'(1);
                    state_d = (BYTE_W == 1) ? ST_LOAD : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!strobe) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_BIT) begin
                    state_d = ST_LOAD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_LOAD: begin
                state_d = strobe ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        shift_en  = 1'b0;
        hold_en   = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   shift_en  = strobe;
            ST_SHIFT:  shift_en  = strobe;
            ST_LOAD:   hold_en   = strobe;
            ST_COMMIT: commit_en = strobe;
            default: ;
        endcase
    end

    assert_load_after_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD) |-> ($past(state_q) == ST_SHIFT || BYTE_W == 1))
        else $error("load state not entered from shift");

    assert_commit_after_load_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_LOAD))
        else $error("commit state not entered from load");

endmodule

// File: rtl/s2p_shift_stage.sv
module s2p_shift_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              hold_en,
    input  logic              din,
    output logic [BYTE_W-1:0] held
);
    logic [BYTE_W-1:0] shreg_q;

    // input stage: MSB first, new bit enters at bit 0
    generate
        if (BYTE_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           shreg_q <= '0;
                else if (shift_en) shreg_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)           shreg_q <= '0;
                else if (shift_en) shreg_q <= {shreg_q[BYTE_W-2:0], din};
            end
        end
    endgenerate

    // holding stage
    always_ff @(posedge clk) begin
        if (rst)          held <= '0;
        else if (hold_en) held <= shreg_q;
    end

endmodule

// File: rtl/s2p_sel_decode.sv
module s2p_sel_decode #(
    parameter int NUM_BYTES = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit_en,
    input  logic [NUM_BYTES-1:0] sel,
    output logic [NUM_BYTES-1:0] wr_en,
    output logic                 err
);
    int   hits;
    logic bad;

    always_comb begin
        hits  = $countones(sel);
        wr_en = '0;
        bad   = 1'b0;
        if (commit_en) begin
            if (hits == 1)     wr_en = sel;
            else if (hits > 1) bad   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= bad;
    end

    assert_err_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        err |=> !err)
        else $error("error flag high longer than one cycle");

endmodule

// File: rtl/s2p_byte_bank.sv
module s2p_byte_bank #(
    parameter int NUM_BYTES = 20,
    parameter int BYTE_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BYTES-1:0]        wr_en,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NUM_BYTES*BYTE_W-1:0] q
);
    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)           q[i*BYTE_W +: BYTE_W] <= '0;
                else if (wr_en[i]) q[i*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/ctl_s2p_bank.sv
module ctl_s2p_bank #(
    parameter int NUM_BYTES = 20,
    parameter int BYTE_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ser_din,
    input  logic                        strobe,
    input  logic [NUM_BYTES-1:0]        byte_sel,
    output logic [NUM_BYTES*BYTE_W-1:0] ctl_out,
    output logic                        sel_err
);
    localparam int OUT_W = NUM_BYTES * BYTE_W;

    logic                 shift_en, hold_en, commit_en;
    logic [BYTE_W-1:0]    held_byte;
    logic [NUM_BYTES-1:0] wr_en;
    logic                 armed;

    s2p_seq_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .shift_en  (shift_en),
        .hold_en   (hold_en),
        .commit_en (commit_en)
    );

    s2p_shift_stage #(.BYTE_W(BYTE_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .hold_en  (hold_en),
        .din      (ser_din),
        .held     (held_byte)
    );

    s2p_sel_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .commit_en (commit_en),
        .sel       (byte_sel),
        .wr_en     (wr_en),
        .err       (sel_err)
    );

    s2p_byte_bank #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (held_byte),
        .q     (ctl_out)
    );

    // qualifies history-based checks once a clean edge has passed
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(strobe) && !$past(rst)) |-> (ctl_out == $past(ctl_out)))
        else $error("outputs changed with strobe low");

    assert_err_blocks_write_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        sel_err |-> (ctl_out == $past(ctl_out)))
        else $error("output changed on a refused write");

    initial begin
        assert (OUT_W == NUM_BYTES * BYTE_W && BYTE_W >= 1 && NUM_BYTES >= 1)
            else $error("bad parameters");
    end

endmodule

// File: tb/ctl_s2p_bank_tb_top.sv
module ctl_s2p_bank_tb_top;
    localparam int NB = 20;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_din = 1'b0;
    logic          strobe = 1'b0;
    logic [NB-1:0] byte_sel = '0;
    logic [NB*BW-1:0] ctl_out;
    logic          sel_err;

    logic [NB*BW-1:0] exp_out = '0;
    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    ctl_s2p_bank #(.NUM_BYTES(NB), .BYTE_W(BW)) dut_i (
        .clk(clk), .rst(rst), .ser_din(ser_din), .strobe(strobe),
        .byte_sel(byte_sel), .ctl_out(ctl_out), .sel_err(sel_err)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    task automatic chk_out(string req, string what);
        nchk++;
        if (ctl_out !== exp_out) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, ctl_out, exp_out);
        end
    endtask

    task automatic chk_err(string req, string what, logic e);
        nchk++;
        if (sel_err !== e) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, sel_err, e);
        end
    endtask

    task automatic step(logic s, logic d, logic [NB-1:0] sel);
        @(negedge clk);
        strobe = s; ser_din = d; byte_sel = sel;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0);
    endtask

    task automatic frame(logic [NB-1:0] sel, logic [BW-1:0] data);
        for (int i = 0; i < 10; i++)
            step(1'b1, (i < 8) ? data[7-i] : 1'b0, sel);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; strobe = 1'b0;
        @(negedge clk); rst = 1'b0;
        exp_out = '0;
    endtask

    task automatic t_reset();
        chk_out("R1", "outputs after reset");
        chk_err("R1", "error flag after reset", 1'b0);
    endtask

    task automatic t_basic();
        frame(NB'(1) << 3, 8'hA5); idle();
        exp_out[3*8 +: 8] = 8'hA5;
        chk_out("R4", "single byte 3 write");
        frame(NB'(1) << 19, 8'h80); idle();
        exp_out[19*8 +: 8] = 8'h80;
        chk_out("R2", "first bit lands in bit 7 of byte 19");
        frame(NB'(1), 8'h01); idle();
        exp_out[7:0] = 8'h01;
        chk_out("R2", "last bit lands in bit 0 of byte 0");
        frame(NB'(1) << 3, 8'h3C); idle();
        exp_out[3*8 +: 8] = 8'h3C;
        chk_out("R4", "overwrite byte 3, others kept");
    endtask

    task automatic t_timing();
        for (int i = 0; i < 9; i++)
            step(1'b1, i[0], NB'(1) << 5);
        step(1'b1, 1'b0, NB'(1) << 5);
        chk_out("R3", "byte 5 unchanged after edge 9");
        idle();
        exp_out[5*8 +: 8] = 8'h55;
        chk_out("R3", "byte 5 updated after edge 10");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 40; i++)
            step(1'b0, i[1], NB'(i * 37 + 1));
        idle();
        chk_out("R5", "no change with strobe low");
    endtask

    task automatic t_zero_sel();
        frame('0, 8'hFF); idle();
        chk_out("R6", "no select lines, no change");
        chk_err("R6", "no error on empty select", 1'b0);
    endtask

    task automatic t_multi_sel();
        frame((NB'(1) << 2) | (NB'(1) << 9), 8'hEE); idle();
        chk_out("R7", "multi select refused");
        chk_err("R7", "error pulse high", 1'b1);
        idle();
        chk_err("R7", "error pulse ends after one cycle", 1'b0);
    endtask

    task automatic t_abort();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, NB'(1) << 7);
        idle();
        frame(NB'(1) << 7, 8'h5A); idle();
        exp_out[7*8 +: 8] = 8'h5A;
        chk_out("R8", "abort in shift then clean frame");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, NB'(1) << 8);
        idle();
        chk_out("R8", "abort before hold edge");
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, NB'(1) << 8);
        idle();
        chk_out("R8", "abort at commit edge");
        frame(NB'(1) << 8, 8'hC3); idle();
        exp_out[8*8 +: 8] = 8'hC3;
        chk_out("R8", "clean frame after aborts");
    endtask

    task automatic t_back2back();
        frame(NB'(1) << 1, 8'h11);
        step(1'b1, 1'b0, NB'(1) << 2);
        exp_out[1*8 +: 8] = 8'h11;
        chk_out("R9", "first of back-to-back frames");
        for (int i = 1; i < 10; i++)
            step(1'b1, (i < 8) ? 8'h22 >> (7 - i) & 1'b1 : 1'b0, NB'(1) << 2);
        idle();
        exp_out[2*8 +: 8] = 8'h22;
        chk_out("R9", "second of back-to-back frames");
    endtask

    task automatic t_addr_late();
        for (int i = 0; i < 9; i++)
            step(1'b1, (i < 8) ? 8'h96 >> (7 - i) & 1'b1 : 1'b0, NB'(1) << 4);
        step(1'b1, 1'b0, NB'(1) << 6);
        idle();
        exp_out[6*8 +: 8] = 8'h96;
        chk_out("R10", "select sampled at commit edge only");
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, NB'(1) << 10);
        do_reset();
        chk_out("R1", "reset mid-frame clears outputs");
        frame(NB'(1) << 10, 8'h0F); idle();
        exp_out[10*8 +: 8] = 8'h0F;
        chk_out("R1", "first frame after reset is clean");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_timing();
        t_hold();
        t_zero_sel();
        t_multi_sel();
        t_abort();
        t_back2back();
        t_addr_late();
        t_reset_mid();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog all requirements: actual hung expected finished");
        summary();
        $finish;
    end

endmodule